// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line carries one of four states: Modified, Exclusive, Shared or Invalid. The processor side takes single-word reads and writes and acknowledges each one. Read misses go out as a bus read, writes that lack ownership go out as a read-for-ownership, and dirty victims are written back before the refill. A read miss that sees no peer assert the wired shared signal installs the line as Exclusive. A later write to that line then completes locally, with no bus traffic.

The snoop side watches the transactions of other caches in the same cycle they appear. On a snooped read that hits a valid line it raises the shared signal. When the line is Modified or Exclusive it flushes the line cache-to-cache and drops the line to Shared. Among several Shared holders, only the holder with the lowest cache number supplies the data. A snooped read-for-ownership invalidates any copy. A Modified line that is flushed also updates memory, so a Shared line is never dirty.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_ack_o` and `bus_req_o` are low, and a snooped read of any address gives no hit, no shared signal and no flush.
- R2: A read miss requests the bus with `bus_cmd_o` = 2'b01 (read) at the request address. The line installs as Exclusive if `bus_shared_i` is low in the grant cycle, and as Shared otherwise. `cpu_rdata_o` returns `bus_rdata_i`, and `cpu_ack_o` pulses for one cycle, in the cycle after the grant.
- R3: A read hit returns the stored word with no bus request, and `cpu_ack_o` is a single-cycle pulse.
- R4: A write that hits an Exclusive or Modified line makes no bus request and leaves the line Modified, holding the written word.
- R5: A write that hits a Shared line, or that misses, requests the bus with `bus_cmd_o` = 2'b10 (read-for-ownership) at the request address. The line becomes Modified, holding the written word.
- R6: A miss whose victim is Modified first requests `bus_cmd_o` = 2'b11 (writeback), carrying the victim's address and data, and then issues the refill. Exclusive and Shared victims are dropped without a writeback.
- R7: A snooped read (`snp_excl_i` = 0) that hits a Modified or Exclusive line asserts `snp_flush_o` with the line data on `snp_data_o`, and the line becomes Shared. `snp_mem_upd_o` is asserted only if the line was Modified.
- R8: A snooped read-for-ownership (`snp_excl_i` = 1) that hits a Modified or Exclusive line flushes the data and leaves the line Invalid. `snp_mem_upd_o` is asserted only if the line was Modified.
- R9: A snooped read-for-ownership that hits a Shared line invalidates it. The line flushes only when it is the selected supplier under R11.
- R10: `snp_shared_o` is asserted exactly when a snooped read hits a line in any valid state. It is never asserted for a read-for-ownership or for a miss.
- R11: A Shared line that hits a snoop flushes only if no bit of `snp_hits_i` below index CACHE_ID is set. The block ignores its own bit of `snp_hits_i`. Modified and Exclusive lines always supply.
- R12: If a snoop takes a pending victim out of Modified before the writeback is granted, the writeback is withdrawn and only the refill is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with ack |
| bus_req_o | output | 1 | Bus transaction request |
| bus_cmd_o | output | 2 | 01 read, 10 read-for-ownership, 11 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_gnt_i | input | 1 | Transaction completes this cycle |
| bus_rdata_i | input | DATA_W | Refill data, valid with grant |
| bus_shared_i | input | 1 | Wired shared signal, sampled with grant |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_excl_i | input | 1 | Snooped transaction is read-for-ownership |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_hits_i | input | N_CACHES | Hit indication of every cache, by cache number |
| snp_hit_o | output | 1 | This cache holds the snooped line |
| snp_shared_o | output | 1 | Drive to the wired shared signal |
| snp_flush_o | output | 1 | This cache supplies the line |
| snp_mem_upd_o | output | 1 | Flushed data must also be written to memory |
| snp_data_o | output | DATA_W | Flushed line data |

## Verification
A corrupted line state stays hidden until that line is touched again. It can show up as an extra or missing bus request on the next processor access to the line, as a silent write where ownership should have been requested, or as a wrong hit, shared, flush or memory-update response to the next snoop. A lost Exclusive-to-Modified promotion shows up only when a later snoop or eviction fails to update memory. For that reason the bench mixes snoops with processor traffic on a few sets, so that every state is probed within a few operations of being entered. A stale word is exposed at the next read hit or at the next flush.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_RESP} ctrl_e;
endpackage

// File: rtl/mesi_prio_sel.sv
module mesi_prio_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | req_i[g];
    assign gnt_o[g]  = req_i[g] & ~seen[g];
  end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int N_CACHES = 4,
  parameter int CACHE_ID = 0
) (
  input  logic                valid_i,
  input  logic                excl_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  mesi_e               line_st_i,
  input  logic [TAG_W-1:0]    line_tag_i,
  input  logic [N_CACHES-1:0] hits_i,
  output logic                hit_o,
  output logic                shared_o,
  output logic                flush_o,
  output logic                mem_upd_o,
  output mesi_e               next_st_o
);
  logic                hit;
  logic                owner;
  logic [N_CACHES-1:0] hits_mix;
  logic [N_CACHES-1:0] sel;

  assign hit   = valid_i && (line_st_i != ST_I) && (line_tag_i == tag_i);
  assign owner = (line_st_i == ST_M) || (line_st_i == ST_E);

  // own bit comes from the local lookup, not from the bus
  always_comb begin
    hits_mix           = hits_i;
    hits_mix[CACHE_ID] = hit;
  end

  mesi_prio_sel #(.N(N_CACHES)) i_sel (
    .req_i (hits_mix),
    .gnt_o (sel)
  );

  assign hit_o     = hit;
  assign shared_o  = hit && !excl_i;
  assign flush_o   = hit && (owner || sel[CACHE_ID]);
  assign mem_upd_o = flush_o && (line_st_i == ST_M);
  assign next_st_o = excl_i ? ST_I : ST_S;
endmodule

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output mesi_e             cpu_st_o,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output logic [DATA_W-1:0] cpu_data_o,
  input  logic              cpu_st_we_i,
  input  mesi_e             cpu_st_i,
  input  logic              cpu_line_we_i,
  input  logic [TAG_W-1:0]  cpu_tag_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output mesi_e             snp_st_o,
  output logic [TAG_W-1:0]  snp_tag_o,
  output logic [DATA_W-1:0] snp_data_o,
  input  logic              snp_st_we_i,
  input  mesi_e             snp_st_i
);
  mesi_e             st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  // snoop write is last, so it wins on a same-set collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= ST_I;
    end else begin
      if (cpu_st_we_i) st_q[cpu_idx_i] <= cpu_st_i;
      if (snp_st_we_i) st_q[snp_idx_i] <= snp_st_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (cpu_line_we_i) begin
      tag_q[cpu_idx_i]  <= cpu_tag_i;
      data_q[cpu_idx_i] <= cpu_data_i;
    end
  end

  assign cpu_st_o   = st_q[cpu_idx_i];
  assign cpu_tag_o  = tag_q[cpu_idx_i];
  assign cpu_data_o = data_q[cpu_idx_i];
  assign snp_st_o   = st_q[snp_idx_i];
  assign snp_tag_o  = tag_q[snp_idx_i];
  assign snp_data_o = data_q[snp_idx_i];
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int SETS     = 16,
  parameter int N_CACHES = 4,
  parameter int CACHE_ID = 2,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  output logic                cpu_ack_o,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  output logic                bus_req_o,
  output logic [1:0]          bus_cmd_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic                bus_gnt_i,
  input  logic [DATA_W-1:0]   bus_rdata_i,
  input  logic                bus_shared_i,
  input  logic                snp_valid_i,
  input  logic                snp_excl_i,
  input  logic [ADDR_W-1:0]   snp_addr_i,
  input  logic [N_CACHES-1:0] snp_hits_i,
  output logic                snp_hit_o,
  output logic                snp_shared_o,
  output logic                snp_flush_o,
  output logic                snp_mem_upd_o,
  output logic [DATA_W-1:0]   snp_data_o
);
  ctrl_e             fsm_q, fsm_d;
  logic              req_we_q;
  logic [TAG_W-1:0]  req_tag_q;
  logic [IDX_W-1:0]  req_idx_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic [IDX_W-1:0]  lk_idx;
  mesi_e             lk_st;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              lk_hit;
  logic              accept;

  logic              st_we, line_we;
  mesi_e             st_wr;
  logic [TAG_W-1:0]  tag_wr;
  logic [DATA_W-1:0] data_wr;

  mesi_e             snp_st, snp_next;
  logic [TAG_W-1:0]  snp_line_tag;
  logic              snp_hit;

  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign lk_idx  = (fsm_q == F_IDLE) ? cpu_idx : req_idx_q;
  assign lk_hit  = (lk_st != ST_I) && (lk_tag == cpu_tag);
  // a snoop takes the array first; the processor waits one cycle
  assign accept  = (fsm_q == F_IDLE) && cpu_req_i && !snp_valid_i;

  mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cpu_idx_i     (lk_idx),
    .cpu_st_o      (lk_st),
    .cpu_tag_o     (lk_tag),
    .cpu_data_o    (lk_data),
    .cpu_st_we_i   (st_we),
    .cpu_st_i      (st_wr),
    .cpu_line_we_i (line_we),
    .cpu_tag_i     (tag_wr),
    .cpu_data_i    (data_wr),
    .snp_idx_i     (snp_addr_i[IDX_W-1:0]),
    .snp_st_o      (snp_st),
    .snp_tag_o     (snp_line_tag),
    .snp_data_o    (snp_data_o),
    .snp_st_we_i   (snp_hit),
    .snp_st_i      (snp_next)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W), .N_CACHES(N_CACHES), .CACHE_ID(CACHE_ID)) i_snoop (
    .valid_i    (snp_valid_i),
    .excl_i     (snp_excl_i),
    .tag_i      (snp_addr_i[ADDR_W-1:IDX_W]),
    .line_st_i  (snp_st),
    .line_tag_i (snp_line_tag),
    .hits_i     (snp_hits_i),
    .hit_o      (snp_hit),
    .shared_o   (snp_shared_o),
    .flush_o    (snp_flush_o),
    .mem_upd_o  (snp_mem_upd_o),
    .next_st_o  (snp_next)
  );
  assign snp_hit_o = snp_hit;

  always_comb begin
    fsm_d   = fsm_q;
    rdata_d = rdata_q;
    st_we   = 1'b0;
    st_wr   = ST_I;
    line_we = 1'b0;
    tag_wr  = req_tag_q;
    data_wr = req_wdata_q;
    unique case (fsm_q)
      F_IDLE: if (accept) begin
        if (lk_hit && !cpu_we_i) begin
          rdata_d = lk_data;
          fsm_d   = F_RESP;
        end else if (lk_hit && (lk_st == ST_E || lk_st == ST_M)) begin
          st_we   = 1'b1;
          st_wr   = ST_M;
          line_we = 1'b1;
          tag_wr  = cpu_tag;
          data_wr = cpu_wdata_i;
          fsm_d   = F_RESP;
        end else if (!lk_hit && lk_st == ST_M) begin
          fsm_d = F_WB;
        end else begin
          fsm_d = F_FILL;
        end
      end
      F_WB: begin
        // victim lost ownership to a snoop: nothing left to write back
        if (lk_st != ST_M) begin
          fsm_d = F_FILL;
        end else if (bus_gnt_i) begin
          st_we = 1'b1;
          st_wr = ST_I;
          fsm_d = F_FILL;
        end
      end
      F_FILL: if (bus_gnt_i) begin
        st_we   = 1'b1;
        st_wr   = req_we_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
        line_we = 1'b1;
        data_wr = req_we_q ? req_wdata_q : bus_rdata_i;
        rdata_d = bus_rdata_i;
        fsm_d   = F_RESP;
      end
      F_RESP: fsm_d = F_IDLE;
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q       <= F_IDLE;
      req_we_q    <= 1'b0;
      req_tag_q   <= '0;
      req_idx_q   <= '0;
      req_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      fsm_q   <= fsm_d;
      rdata_q <= rdata_d;
      if (accept) begin
        req_we_q    <= cpu_we_i;
        req_tag_q   <= cpu_tag;
        req_idx_q   <= cpu_idx;
        req_wdata_q <= cpu_wdata_i;
      end
    end
  end

  assign cpu_ack_o   = (fsm_q == F_RESP);
  assign cpu_rdata_o = rdata_q;
  assign bus_req_o   = (fsm_q == F_FILL) || (fsm_q == F_WB && lk_st == ST_M);
  assign bus_wdata_o = lk_data;

  always_comb begin
    bus_cmd_o  = CMD_NONE;
    bus_addr_o = {req_tag_q, req_idx_q};
    if (fsm_q == F_WB && lk_st == ST_M) begin
      bus_cmd_o  = CMD_WB;
      bus_addr_o = {lk_tag, req_idx_q};
    end else if (fsm_q == F_FILL) begin
      bus_cmd_o = req_we_q ? CMD_RDX : CMD_RD;
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl_sva.sv
module mesi_snoop_ctrl_sva
  import mesi_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_ack_o,
  input logic       bus_req_o,
  input logic [1:0] bus_cmd_o,
  input logic       bus_gnt_i,
  input logic       snp_valid_i,
  input logic       snp_excl_i,
  input logic       snp_hit_o,
  input logic       snp_shared_o,
  input logic       snp_flush_o,
  input logic       snp_mem_upd_o
);
  a_r3_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);

  a_r2_ack_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o != CMD_WB) |=> cpu_ack_o);

  a_r6_wb_before_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_gnt_i && bus_req_o && bus_cmd_o == CMD_WB) |=> !cpu_ack_o);

  a_r1_req_has_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_cmd_o != CMD_NONE) && !cpu_ack_o);

  a_r10_shared_on_read_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_shared_o |-> snp_valid_i && !snp_excl_i && snp_hit_o);

  a_r10_hit_needs_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |-> snp_valid_i);

  a_r11_flush_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> snp_hit_o);

  a_r7_upd_needs_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_mem_upd_o |-> snp_flush_o);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_sva i_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_ack_o     (cpu_ack_o),
  .bus_req_o     (bus_req_o),
  .bus_cmd_o     (bus_cmd_o),
  .bus_gnt_i     (bus_gnt_i),
  .snp_valid_i   (snp_valid_i),
  .snp_excl_i    (snp_excl_i),
  .snp_hit_o     (snp_hit_o),
  .snp_shared_o  (snp_shared_o),
  .snp_flush_o   (snp_flush_o),
  .snp_mem_upd_o (snp_mem_upd_o)
);

// File: tb/test_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_mesi_snoop_ctrl;
  localparam int AW = 10, DW = 32, NS = 16, NC = 4, CID = 2, IW = 4;
  localparam int SI = 0, SS = 1, SE = 2, SM = 3;
  localparam logic [1:0] C_RD = 2'b01, C_RDX = 2'b10, C_WB = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, bus_shared = 0, snp_valid = 0, snp_excl = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, bus_rdata = '0;
  logic [NC-1:0] snp_hits = '0;
  logic cpu_ack, bus_req, snp_hit, snp_shared, snp_flush, snp_mem_upd;
  logic [DW-1:0] cpu_rdata, bus_wdata, snp_data;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;

  int n_checks = 0, n_fail = 0;
  int est [NS];
  logic [AW-IW-1:0] etag [NS];
  logic [DW-1:0] edat [NS];
  logic [DW-1:0] mem [1 << AW];

  always #4 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .N_CACHES(NC), .CACHE_ID(CID)) i_mesi_snoop_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_gnt_i(bus_gnt), .bus_rdata_i(bus_rdata), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_excl_i(snp_excl), .snp_addr_i(snp_addr), .snp_hits_i(snp_hits),
    .snp_hit_o(snp_hit), .snp_shared_o(snp_shared), .snp_flush_o(snp_flush),
    .snp_mem_upd_o(snp_mem_upd), .snp_data_o(snp_data)
  );

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [AW-1:0] mk(input int t, input int i);
    logic [AW-IW-1:0] tt = t[AW-IW-1:0];
    logic [IW-1:0] ii = i[IW-1:0];
    return {tt, ii};
  endfunction

  task automatic snoop_op(input bit excl, input logic [AW-1:0] a, input logic [NC-1:0] vec);
    int idx = int'(a[IW-1:0]);
    int st = est[idx];
    bit hit = (st != SI) && (etag[idx] == a[AW-1:IW]);
    bit lower = |vec[CID-1:0];
    bit e_sh = hit && !excl;
    bit e_fl = hit && (st == SM || st == SE || (st == SS && !lower));
    bit e_up = e_fl && st == SM;
    string rq;
    if (!hit) rq = "R10";
    else if (st == SS) rq = excl ? "R9" : "R11";
    else rq = excl ? "R8" : "R7";
    snp_valid = 1; snp_excl = excl; snp_addr = a; snp_hits = vec;
    #1;
    chk(snp_shared == e_sh, "R10", "snoop shared", snp_shared, e_sh);
    chk(snp_flush == e_fl, rq, "snoop flush", snp_flush, e_fl);
    chk(snp_mem_upd == e_up, rq, "memory update", snp_mem_upd, e_up);
    if (e_fl) chk(snp_data == edat[idx], rq, "flush data", snp_data, edat[idx]);
    if (e_up) mem[a] = edat[idx];
    if (hit) est[idx] = excl ? SI : SS;
    @(posedge clk); @(negedge clk);
    snp_valid = 0;
  endtask

  // shmode: 0 shared low, 1 shared high, 2 random
  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input int shmode, input bit snoop_victim);
    int idx = int'(a[IW-1:0]);
    bit hit = (est[idx] != SI) && (etag[idx] == a[AW-1:IW]);
    bit need_wb = !hit && est[idx] == SM;
    logic [AW-1:0] wb_a = {etag[idx], a[IW-1:0]};
    logic [DW-1:0] wb_d = edat[idx];
    bit need_fill = !(hit && (!we || est[idx] == SE || est[idx] == SM));
    bit wb_done = 0, fill_done = 0, acked = 0, sh = 0;
    logic [DW-1:0] fill_d = '0, got = '0;
    string rq = we ? (need_fill ? "R5" : "R4") : (need_fill ? "R2" : "R3");
    int cyc = 0;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!acked && cyc < 60) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      bus_gnt = 0;
      if (cpu_ack) begin
        acked = 1; got = cpu_rdata; cpu_req = 0;
      end else if (bus_req) begin
        if (snoop_victim && need_wb && !wb_done) begin
          snoop_op(1'b1, wb_a, '0);
          need_wb = 0;
        end else if ($urandom_range(0, 2) != 0) begin
          if (bus_cmd == C_WB) begin
            chk(need_wb && !wb_done, "R6", "unexpected writeback", 1, 0);
            chk(bus_addr == wb_a, "R6", "writeback address", bus_addr, wb_a);
            chk(bus_wdata == wb_d, "R6", "writeback data", bus_wdata, wb_d);
            mem[bus_addr] = bus_wdata;
            wb_done = 1;
          end else begin
            chk(need_fill && !fill_done && (!need_wb || wb_done), rq, "unexpected fill", 1, 0);
            chk(bus_cmd == (we ? C_RDX : C_RD), rq, "fill command", bus_cmd, we ? C_RDX : C_RD);
            chk(bus_addr == a, rq, "fill address", bus_addr, a);
            sh = (shmode == 2) ? 1'($urandom_range(0, 1)) : 1'(shmode);
            fill_d = mem[a];
            bus_rdata = fill_d; bus_shared = sh;
            fill_done = 1;
          end
          bus_gnt = 1;
        end
      end
    end
    bus_gnt = 0; cpu_req = 0;
    chk(acked, rq, "acknowledge seen", acked, 1);
    chk(fill_done == need_fill, rq, "refill issued", fill_done, need_fill);
    chk(wb_done == need_wb, snoop_victim ? "R12" : "R6", "writeback issued", wb_done, need_wb);
    if (!we) begin
      logic [DW-1:0] e = need_fill ? fill_d : edat[idx];
      chk(got == e, rq, "read data", got, e);
    end
    if (need_fill) begin
      est[idx] = we ? SM : (sh ? SS : SE);
      etag[idx] = a[AW-1:IW];
      edat[idx] = we ? wd : fill_d;
    end else if (we) begin
      est[idx] = SM; edat[idx] = wd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin est[i] = SI; etag[i] = '0; edat[i] = '0; end
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h9e37_0000 ^ (i * 32'h0001_0193);
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(cpu_ack == 0, "R1", "ack after reset", cpu_ack, 0);
    chk(bus_req == 0, "R1", "bus request after reset", bus_req, 0);
    snoop_op(1'b0, mk(1, 0), '0);
    // R2 exclusive fill, then R7/R10 supply from E
    cpu_op(0, mk(1, 0), '0, 0, 0);
    snoop_op(1'b0, mk(1, 0), 4'b0011);
    // R5 upgrade from S, R7 dirty flush with memory update
    cpu_op(1, mk(1, 0), 32'hA5A5_0001, 2, 0);
    snoop_op(1'b0, mk(1, 0), 4'b0000);
    cpu_op(0, mk(1, 0), '0, 2, 0);
    // R4 silent E->M, R8 dirty invalidation
    cpu_op(0, mk(2, 1), '0, 0, 0);
    cpu_op(1, mk(2, 1), 32'h1234_5678, 2, 0);
    snoop_op(1'b1, mk(2, 1), 4'b0001);
    cpu_op(0, mk(2, 1), '0, 1, 0);
    // R11 supplier selection among sharers, R9 invalidation of S
    cpu_op(0, mk(3, 2), '0, 1, 0);
    snoop_op(1'b0, mk(3, 2), 4'b0010);
    snoop_op(1'b0, mk(3, 2), 4'b1100);
    snoop_op(1'b1, mk(3, 2), 4'b0001);
    snoop_op(1'b0, mk(3, 2), 4'b0000);
    // R6 dirty and clean victims
    cpu_op(1, mk(4, 5), 32'hDEAD_0005, 2, 0);
    cpu_op(0, mk(5, 5), '0, 0, 0);
    cpu_op(0, mk(6, 5), '0, 1, 0);
    // R12 writeback withdrawn after snoop steals the victim
    cpu_op(1, mk(7, 6), 32'h0BAD_0006, 2, 0);
    cpu_op(0, mk(8, 6), '0, 2, 1);
    // constrained random mix on four sets and four tags
    for (int n = 0; n < 1500; n++) begin
      logic [AW-1:0] ra = mk($urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 9) < 6)
        cpu_op(1'($urandom_range(0, 1)), ra, $urandom, 2, 0);
      else
        snoop_op(1'($urandom_range(0, 1)), ra, 4'($urandom_range(0, 15)));
    end
    report();
  end
endmodule